// File: doc/BRIEF.md
# Blocked Cube Address Walker

This block produces the read addresses for a three-dimensional image cube that is stored pixel-interleaved in memory, visiting the cube one rectangular block at a time. Every spectral component of a pixel sits at consecutive component positions. A pixel's successor in the same row sits one depth further on. A row's successor sits one cube width further on. A downstream reader takes each address through a valid/ready handshake and turns it into memory reads.

Configuration is held on plain input ports that a register interface drives. These ports carry the base address, the start offset, the cube width, the block shape, two skip distances and the block counts. A rising edge on the start input launches a walk. Addresses count in components and are scaled to bytes by a fixed component size of `2**COMP_BYTES_LOG2` bytes. The default size is 2 bytes.

The controller has two states. `S_IDLE` waits for a start edge; that transition is named launch. `S_WALK` presents one address per accepted handshake and returns to `S_IDLE` on the final beat; that transition is named finish. At finish the done bit is set. The completion flag and the interrupt line are also set at finish, but only when the completion interrupt is enabled.

Top module: `cwag_top`

## Requirements
- R1: A walk is launched only by a 0-to-1 change of `cfg_start` while idle. Keeping it at 1 after a walk starts no new walk. A rising edge during a walk leaves the address sequence unchanged.
- R2: The first address of a walk is `cfg_base + cfg_offset*2` in bytes, with the default component size of 2 bytes.
- R3: Within one pixel the `cfg_depth` components are emitted consecutively, each 2 bytes above the previous one. Depth is the actual count.
- R4: After the last component of a pixel, the next pixel of the same block row starts `cfg_depth` components after the previous pixel's start. There are `cfg_blk_w_m1+1` pixels per block row.
- R5: After the last pixel of a block row, the next row starts `cfg_cube_w` components after the previous row's start. There are `cfg_blk_h_m1+1` rows per block.
- R6: After a block that is not the last block of its row of blocks, the next block starts `cfg_skip` components after the current block's first component.
- R7: After the last block of a row of blocks, the next block starts `cfg_last_skip` components after the current block's first component. There are `cfg_nbx_m1+1` blocks along X. X is walked inside Y, and there are `cfg_nby_m1+1` rows of blocks.
- R8: While `addr_valid` is 1 and `addr_ready` is 0, `addr` and `addr_valid` hold their values into the next cycle.
- R9: In the cycle after the final accepted address, `addr_valid` is 0 and `done` is 1. A launch clears `done`.
- R10: `cmp_flag` and `irq` become 1 at finish only if `cfg_cmp_irq_en` is 1. A one-cycle pulse on `cfg_flag_clr` clears both.
- R11: After reset, `addr_valid`, `done`, `cmp_flag` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Start control bit; its rising edge launches a walk |
| cfg_cmp_irq_en | input | 1 | Completion interrupt enable |
| cfg_flag_clr | input | 1 | Write-one pulse clearing the completion flag |
| cfg_base | input | 32 | Byte address of the cube |
| cfg_offset | input | 32 | Start offset in components from the cube start |
| cfg_cube_w | input | 20 | Cube width in components (row stride) |
| cfg_blk_w_m1 | input | 12 | Block width in pixels minus one |
| cfg_blk_h_m1 | input | 12 | Block height in rows minus one |
| cfg_depth | input | 8 | Components per pixel |
| cfg_skip | input | 16 | Component distance to the next block in a row |
| cfg_last_skip | input | 16 | Component distance used after the last block of a row |
| cfg_nbx_m1 | input | 9 | Blocks along X minus one |
| cfg_nby_m1 | input | 9 | Blocks along Y minus one |
| addr_valid | output | 1 | Address available |
| addr_ready | input | 1 | Consumer accepts the address |
| addr | output | 32 | Byte address of the current component |
| done | output | 1 | Walk complete |
| cmp_flag | output | 1 | Completion interrupt flag |
| irq | output | 1 | Interrupt line |

## Verification
The hardest situation to reach is the switch from the normal skip to the last-block skip. It also has to coincide with the rollover of all five nested counters on a beat the consumer is stalling. The vectors therefore use several blocks along both X and Y, with block widths, heights and depths above one. The ready pattern varies per vector, so that stalls fall on every kind of boundary. A start edge is also injected mid-walk to show that it cannot disturb the sequence.

// File: rtl/cwag_pkg.sv
package cwag_pkg;
    typedef enum logic {
        S_IDLE,
        S_WALK
    } walk_state_e;
endpackage

// File: rtl/cwag_cnt.sv
module cwag_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] lim,
    output logic [W-1:0] val,
    output logic         last
);
    assign last = (val == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            val <= '0;
        else if (clr)
            val <= '0;
        else if (inc)
            val <= last ? '0 : val + W'(1);
    end

    // Counter wraps to zero after its limit (R4, R5, R7 shape)
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && last && !clr) |=> (val == '0));
endmodule

// File: rtl/cwag_ptr.sv
module cwag_ptr #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          beat,
    input  logic          d_last,
    input  logic          c_last,
    input  logic          r_last,
    input  logic [CW-1:0] pix_step,
    input  logic [CW-1:0] row_step,
    input  logic [CW-1:0] blk_step,
    output logic [CW-1:0] cur
);
    logic [CW-1:0] blk_o, row_o, pix_o;
    logic [CW-1:0] pix_nx, row_nx, blk_nx;

    always_comb begin
        pix_nx = pix_o + pix_step;
        row_nx = row_o + row_step;
        blk_nx = blk_o + blk_step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_o <= '0;
            row_o <= '0;
            pix_o <= '0;
            cur   <= '0;
        end else if (load) begin
            blk_o <= load_val;
            row_o <= load_val;
            pix_o <= load_val;
            cur   <= load_val;
        end else if (beat) begin
            if (!d_last) begin
                cur <= cur + CW'(1);
            end else if (!c_last) begin
                pix_o <= pix_nx;
                cur   <= pix_nx;
            end else if (!r_last) begin
                row_o <= row_nx;
                pix_o <= row_nx;
                cur   <= row_nx;
            end else begin
                blk_o <= blk_nx;
                row_o <= blk_nx;
                pix_o <= blk_nx;
                cur   <= blk_nx;
            end
        end
    end

    // Inside a pixel the component index steps by one (R3)
    p_depth_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !d_last && !load) |=> (cur == $past(cur) + CW'(1)));
    // Pointer is frozen when no beat happens (R8)
    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat && !load) |=> $stable(cur));
endmodule

// File: rtl/cwag_top.sv
module cwag_top
    import cwag_pkg::*;
#(
    parameter int AW              = 32,
    parameter int CUBE_W_BITS     = 20,
    parameter int BDIM_BITS       = 12,
    parameter int DEPTH_BITS      = 8,
    parameter int SKIP_BITS       = 16,
    parameter int NBLK_BITS       = 9,
    parameter int COMP_BYTES_LOG2 = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_start,
    input  logic                   cfg_cmp_irq_en,
    input  logic                   cfg_flag_clr,
    input  logic [AW-1:0]          cfg_base,
    input  logic [AW-1:0]          cfg_offset,
    input  logic [CUBE_W_BITS-1:0] cfg_cube_w,
    input  logic [BDIM_BITS-1:0]   cfg_blk_w_m1,
    input  logic [BDIM_BITS-1:0]   cfg_blk_h_m1,
    input  logic [DEPTH_BITS-1:0]  cfg_depth,
    input  logic [SKIP_BITS-1:0]   cfg_skip,
    input  logic [SKIP_BITS-1:0]   cfg_last_skip,
    input  logic [NBLK_BITS-1:0]   cfg_nbx_m1,
    input  logic [NBLK_BITS-1:0]   cfg_nby_m1,
    output logic                   addr_valid,
    input  logic                   addr_ready,
    output logic [AW-1:0]          addr,
    output logic                   done,
    output logic                   cmp_flag,
    output logic                   irq
);
    localparam int DEPTH_FULL = 1 << DEPTH_BITS;

    walk_state_e state, state_nx;
    logic start_q, start_rise, launch;
    logic beat, blk_end, walk_end;
    logic d_last, c_last, r_last, bx_last, by_last;
    logic [DEPTH_BITS-1:0] d_val, d_lim;
    logic [BDIM_BITS-1:0]  c_val, r_val;
    logic [NBLK_BITS-1:0]  bx_val, by_val;
    logic [AW-1:0] cur, pix_step, blk_step;

    assign start_rise = cfg_start && !start_q;
    assign launch     = (state == S_IDLE) && start_rise;
    assign addr_valid = (state == S_WALK);
    assign beat       = addr_valid && addr_ready;
    assign blk_end    = beat && d_last && c_last && r_last;
    assign walk_end   = blk_end && bx_last && by_last;

    assign d_lim    = cfg_depth - DEPTH_BITS'(1);
    assign pix_step = (cfg_depth == '0) ? AW'(DEPTH_FULL) : AW'(cfg_depth);
    assign blk_step = bx_last ? AW'(cfg_last_skip) : AW'(cfg_skip);
    assign addr     = cfg_base + (cur << COMP_BYTES_LOG2);
    assign irq      = cmp_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            start_q <= 1'b0;
        end else begin
            state   <= state_nx;
            start_q <= cfg_start;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (launch)   state_nx = S_WALK;
            S_WALK: if (walk_end) state_nx = S_IDLE;
            default:              state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            cmp_flag <= 1'b0;
        end else begin
            if (launch)        done <= 1'b0;
            else if (walk_end) done <= 1'b1;
            if (walk_end && cfg_cmp_irq_en) cmp_flag <= 1'b1;
            else if (cfg_flag_clr)          cmp_flag <= 1'b0;
        end
    end

    cwag_cnt #(.W(DEPTH_BITS)) u_cnt_d (
        .clk(clk), .rst_n(rst_n), .clr(launch), .inc(beat),
        .lim(d_lim), .val(d_val), .last(d_last));
    cwag_cnt #(.W(BDIM_BITS)) u_cnt_c (
        .clk(clk), .rst_n(rst_n), .clr(launch), .inc(beat && d_last),
        .lim(cfg_blk_w_m1), .val(c_val), .last(c_last));
    cwag_cnt #(.W(BDIM_BITS)) u_cnt_r (
        .clk(clk), .rst_n(rst_n), .clr(launch), .inc(beat && d_last && c_last),
        .lim(cfg_blk_h_m1), .val(r_val), .last(r_last));
    cwag_cnt #(.W(NBLK_BITS)) u_cnt_bx (
        .clk(clk), .rst_n(rst_n), .clr(launch), .inc(blk_end),
        .lim(cfg_nbx_m1), .val(bx_val), .last(bx_last));
    cwag_cnt #(.W(NBLK_BITS)) u_cnt_by (
        .clk(clk), .rst_n(rst_n), .clr(launch), .inc(blk_end && bx_last),
        .lim(cfg_nby_m1), .val(by_val), .last(by_last));

    cwag_ptr #(.CW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(launch), .load_val(cfg_offset),
        .beat(beat), .d_last(d_last), .c_last(c_last), .r_last(r_last),
        .pix_step(pix_step), .row_step(AW'(cfg_cube_w)), .blk_step(blk_step),
        .cur(cur));

    // Idle without a start edge stays idle (R1)
    p_no_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start_rise) |=> !addr_valid);
    // Stalled address is held (R8)
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr)));
    // Done only rises right after an accepted address (R9)
    p_done_after_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(addr_valid && addr_ready));
    // Flag only rises when enabled (R10)
    p_flag_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_flag) |-> $past(cfg_cmp_irq_en));
    // Counter values stay inside their limits while walking (R7)
    p_blk_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (bx_val <= cfg_nbx_m1 && by_val <= cfg_nby_m1
                        && c_val <= cfg_blk_w_m1 && r_val <= cfg_blk_h_m1
                        && (cfg_depth == '0 || d_val < cfg_depth)));
endmodule

// File: tb/cwag_top_bench.sv
module cwag_top_bench;
    typedef struct packed {
        logic [31:0] base;
        logic [31:0] off;
        logic [19:0] cw;
        logic [11:0] bw;
        logic [11:0] bh;
        logic [7:0]  dep;
        logic [15:0] sk;
        logic [15:0] lsk;
        logic [8:0]  nbx;
        logic [8:0]  nby;
        logic        ien;
        logic [3:0]  rpat;
    } vec_t;

    localparam int NV = 3;
    localparam vec_t VECS [NV] = '{
        '{32'h1000, 32'd5, 20'd40, 12'd0, 12'd0, 8'd1, 16'd3, 16'd7,  9'd0, 9'd0, 1'b1, 4'd1},
        '{32'h2000, 32'd0, 20'd20, 12'd1, 12'd1, 8'd2, 16'd4, 16'd40, 9'd1, 9'd1, 1'b0, 4'd2},
        '{32'h0100, 32'd3, 20'd30, 12'd2, 12'd0, 8'd3, 16'd9, 16'd30, 9'd2, 9'd1, 1'b1, 4'd3}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_start = 1'b0, cfg_cmp_irq_en = 1'b0, cfg_flag_clr = 1'b0;
    logic [31:0] cfg_base = '0, cfg_offset = '0;
    logic [19:0] cfg_cube_w = '0;
    logic [11:0] cfg_blk_w_m1 = '0, cfg_blk_h_m1 = '0;
    logic [7:0]  cfg_depth = 8'd1;
    logic [15:0] cfg_skip = '0, cfg_last_skip = '0;
    logic [8:0]  cfg_nbx_m1 = '0, cfg_nby_m1 = '0;
    logic addr_ready = 1'b0;
    logic addr_valid, done, cmp_flag, irq;
    logic [31:0] addr;

    int checks = 0, errors = 0, cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cwag_top u_cwag_top (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start),
        .cfg_cmp_irq_en(cfg_cmp_irq_en), .cfg_flag_clr(cfg_flag_clr),
        .cfg_base(cfg_base), .cfg_offset(cfg_offset), .cfg_cube_w(cfg_cube_w),
        .cfg_blk_w_m1(cfg_blk_w_m1), .cfg_blk_h_m1(cfg_blk_h_m1),
        .cfg_depth(cfg_depth), .cfg_skip(cfg_skip), .cfg_last_skip(cfg_last_skip),
        .cfg_nbx_m1(cfg_nbx_m1), .cfg_nby_m1(cfg_nby_m1),
        .addr_valid(addr_valid), .addr_ready(addr_ready), .addr(addr),
        .done(done), .cmp_flag(cmp_flag), .irq(irq));

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            summary();
        end
    end

    task automatic run_walk(input vec_t v);
        logic [31:0] blk, comp, exp;
        int k = 0, cyc = 0;
        bit rdy, consumed, stalled;
        string tag;
        cfg_base = v.base; cfg_offset = v.off; cfg_cube_w = v.cw;
        cfg_blk_w_m1 = v.bw; cfg_blk_h_m1 = v.bh; cfg_depth = v.dep;
        cfg_skip = v.sk; cfg_last_skip = v.lsk; cfg_nbx_m1 = v.nbx;
        cfg_nby_m1 = v.nby; cfg_cmp_irq_en = v.ien;
        @(negedge clk);
        cfg_start = 1'b1;
        @(negedge clk);
        chk(!done, "R9 launch clears done", 32'(done), 0);
        blk = v.off;
        for (int by = 0; by <= int'(v.nby); by++) begin
            for (int bx = 0; bx <= int'(v.nbx); bx++) begin
                for (int r = 0; r <= int'(v.bh); r++) begin
                    for (int c = 0; c <= int'(v.bw); c++) begin
                        for (int d = 0; d < int'(v.dep); d++) begin
                            comp = blk + 32'(r) * 32'(v.cw) + 32'(c) * 32'(v.dep) + 32'(d);
                            exp = v.base + (comp << 1);
                            if (k == 0)                         tag = "R2";
                            else if (d != 0)                    tag = "R3";
                            else if (c != 0)                    tag = "R4";
                            else if (r != 0)                    tag = "R5";
                            else if (bx != 0)                   tag = "R6";
                            else                                tag = "R7";
                            if (k == 2) cfg_start = 1'b0;
                            if (k == 3) cfg_start = 1'b1;   // R1: rise mid-walk ignored
                            consumed = 0;
                            stalled = 0;
                            while (!consumed) begin
                                chk(addr_valid && addr == exp, stalled ? "R8" : tag, addr, exp);
                                rdy = ((cyc % int'(v.rpat)) == 0);
                                cyc++;
                                addr_ready = rdy;
                                @(negedge clk);
                                consumed = rdy;
                                stalled = !rdy;
                            end
                            k++;
                        end
                    end
                end
                blk = blk + ((bx == int'(v.nbx)) ? 32'(v.lsk) : 32'(v.sk));
            end
        end
        addr_ready = 1'b0;
        chk(!addr_valid, "R9 valid drops", 32'(addr_valid), 0);
        chk(done, "R9 done set", 32'(done), 1);
        chk(cmp_flag == v.ien, "R10 flag", 32'(cmp_flag), 32'(v.ien));
        chk(irq == v.ien, "R10 irq", 32'(irq), 32'(v.ien));
        cfg_start = 1'b1;
        repeat (3) @(negedge clk);
        chk(!addr_valid, "R1 held start no relaunch", 32'(addr_valid), 0);
        cfg_start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!addr_valid, "R11 valid", 32'(addr_valid), 0);
        chk(!done, "R11 done", 32'(done), 0);
        chk(!cmp_flag && !irq, "R11 irq", 32'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            run_walk(VECS[i]);
            if (VECS[i].ien) begin
                cfg_flag_clr = 1'b1;
                @(negedge clk);
                cfg_flag_clr = 1'b0;
                chk(!cmp_flag && !irq, "R10 clear", 32'(irq), 0);
            end
        end
        summary();
    end
endmodule